// File: doc/BRIEF.md
# CRC-32 Barrett Reduction Stage

This block finishes a folded CRC-32 computation. It takes a 64-bit remainder polynomial in the bit-reflected (least-significant-bit-first) domain and reduces it modulo the Ethernet generator polynomial to a 32-bit remainder. It does not divide. It uses two carry-less multiplications. The first multiplies the low 32-bit word of the operand by a precomputed reflected reciprocal, 0x1F7011641. The second multiplies the low 32 bits of that product by the reflected polynomial shifted left by one place, 0x1DB710641. The upper word of the operand XOR the second product is the remainder.

A folding engine upstream presents one operand per cycle with a valid strobe. The result leaves the block some fixed number of cycles later with its own one-cycle valid strobe. The pipeline depth can be set to two or three register stages. Byte ordering, the earlier folding steps and the inversion of the CRC before and after the computation all belong to the surrounding logic.

Top module: `crc32_barrett_reduce`

## Requirements
- R1: For every accepted operand R, `crcOut` equals rev32(rev64(R) mod G). Here rev reverses bit order, G is 0x104C11DB7 in the normal domain, and operand bit i stands for x^(63-i).
- R2: `outValid` rises exactly LATENCY rising edges after the edge that samples `inValid` high. LATENCY defaults to 3.
- R3: Operands presented on consecutive cycles are all accepted. Each one produces its own one-cycle `outValid` pulse, on consecutive cycles.
- R4: While `rst` is high, `outValid` is 0 and `crcOut` is 0.
- R5: While `outValid` is low, `crcOut` holds the last result it showed.
- R6: When bits 31:0 of the operand are zero, the result equals bits 63:32 of the operand.
- R7: A value on `inRem` while `inValid` is low produces no `outValid` pulse and leaves `crcOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand strobe |
| inRem | input | 64 | Reflected 64-bit remainder operand |
| outValid | output | 1 | One-cycle result strobe |
| crcOut | output | 32 | Reflected 32-bit CRC remainder |

## Verification
The bound checker assumes that reset is applied before the first operand. It also assumes that `inRem` carries known values whenever `inValid` is high, because its shadow pipeline and its division-based reference copy the operand without qualification. The stimulus always drives defined values, including deliberate junk on idle cycles. It sweeps every single-bit operand and every byte value in each of the eight byte lanes, runs random operands both back-to-back and with gaps, and adds operands whose low word is zero.

// File: rtl/crc32_barrett_pkg.sv
package crc32_barrett_pkg;

  // Strobes from the control path to the datapath, one per register stage.
  typedef struct packed {
    logic capIn;   // load the operand register
    logic capMid;  // load the first-product and upper-word registers
    logic capOut;  // load the result register
  } barrettStrobe_t;

endpackage

// File: rtl/crc32_barrett_ctrl.sv
module crc32_barrett_ctrl
  import crc32_barrett_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  output barrettStrobe_t strb,
  output logic           outValid
);

  logic [LATENCY-1:0] vldPipe;

  always_ff @(posedge clk) begin
    if (rst) vldPipe <= '0;
    else     vldPipe <= {vldPipe[LATENCY-2:0], inValid};
  end

  generate
    if (LATENCY == 3) begin : g_three
      assign strb.capIn  = inValid;
      assign strb.capMid = vldPipe[0];
    end else begin : g_two
      assign strb.capIn  = 1'b0;
      assign strb.capMid = inValid;
    end
  endgenerate

  assign strb.capOut = vldPipe[LATENCY-2];
  assign outValid    = vldPipe[LATENCY-1];

endmodule

// File: rtl/crc32_barrett_datapath.sv
module crc32_barrett_datapath
  import crc32_barrett_pkg::*;
#(
  parameter int              CRC_W   = 32,
  parameter int              LATENCY = 3,
  parameter logic [CRC_W:0]  U_CONST = 33'h1F7011641,
  parameter logic [CRC_W:0]  P_CONST = 33'h1DB710641
) (
  input  logic                 clk,
  input  logic                 rst,
  input  barrettStrobe_t       strb,
  input  logic [2*CRC_W-1:0]   inRem,
  output logic [CRC_W-1:0]     crcOut
);

  localparam int REM_W = 2 * CRC_W;
  localparam logic [CRC_W-1:0] U_LO = U_CONST[CRC_W-1:0];
  localparam logic [REM_W-1:0] P_EXT = REM_W'(P_CONST);

  logic [REM_W-1:0] remS1;
  logic [CRC_W-1:0] t1Lo;
  logic [CRC_W-1:0] t1Reg;
  logic [CRC_W-1:0] hiReg;
  logic [REM_W-1:0] t2Full;
  logic [CRC_W-1:0] t2Hi;
  logic [CRC_W-1:0] crcReg;

  generate
    if (LATENCY == 3) begin : g_inreg
      logic [REM_W-1:0] remReg;
      always_ff @(posedge clk) begin
        if (rst)             remReg <= '0;
        else if (strb.capIn) remReg <= inRem;
      end
      assign remS1 = remReg;
    end else begin : g_nore
      assign remS1 = inRem;
    end
  endgenerate

  // Stage one: low word of the operand times the reciprocal, low word kept.
  always_comb begin
    t1Lo = '0;
    for (int i = 0; i < CRC_W; i++) begin
      if (remS1[i]) t1Lo = t1Lo ^ (U_LO << i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t1Reg <= '0;
      hiReg <= '0;
    end else if (strb.capMid) begin
      t1Reg <= t1Lo;
      hiReg <= remS1[REM_W-1:CRC_W];
    end
  end

  // Stage two: first product times the shifted polynomial, upper word kept.
  always_comb begin
    t2Full = '0;
    for (int i = 0; i < CRC_W; i++) begin
      if (t1Reg[i]) t2Full = t2Full ^ (P_EXT << i);
    end
  end

  assign t2Hi = CRC_W'(t2Full >> CRC_W);

  always_ff @(posedge clk) begin
    if (rst)              crcReg <= '0;
    else if (strb.capOut) crcReg <= hiReg ^ t2Hi;
  end

  assign crcOut = crcReg;

endmodule

// File: rtl/crc32_barrett_reduce.sv
module crc32_barrett_reduce
  import crc32_barrett_pkg::*;
#(
  parameter int              CRC_W   = 32,
  parameter int              LATENCY = 3,
  parameter logic [CRC_W:0]  U_CONST = 33'h1F7011641,
  parameter logic [CRC_W:0]  P_CONST = 33'h1DB710641
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [2*CRC_W-1:0]   inRem,
  output logic                 outValid,
  output logic [CRC_W-1:0]     crcOut
);

  barrettStrobe_t strb;

  crc32_barrett_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  crc32_barrett_datapath #(
    .CRC_W   (CRC_W),
    .LATENCY (LATENCY),
    .U_CONST (U_CONST),
    .P_CONST (P_CONST)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .inRem  (inRem),
    .crcOut (crcOut)
  );

endmodule

// File: rtl/crc32_barrett_reduce_chk.sv
module crc32_barrett_reduce_chk #(
  parameter int              CRC_W   = 32,
  parameter int              LATENCY = 3,
  parameter logic [CRC_W:0]  P_CONST = 33'h1DB710641
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [2*CRC_W-1:0] inRem,
  input logic               outValid,
  input logic [CRC_W-1:0]   crcOut
);

  localparam int REM_W = 2 * CRC_W;

  logic [LATENCY-1:0] vldSh;
  logic [REM_W-1:0]   remSh [LATENCY];
  logic [REM_W-1:0]   remDue;

  // Reflected-domain reduction: clear each low bit with a shifted polynomial.
  function automatic logic [CRC_W-1:0] refMod(input logic [REM_W-1:0] r);
    logic [REM_W-1:0] v;
    v = r;
    for (int i = 0; i < CRC_W; i++) begin
      if (v[i]) v = v ^ (REM_W'(P_CONST) << i);
    end
    return CRC_W'(v >> CRC_W);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vldSh <= '0;
      for (int i = 0; i < LATENCY; i++) remSh[i] <= '0;
    end else begin
      vldSh    <= {vldSh[LATENCY-2:0], inValid};
      remSh[0] <= inRem;
      for (int i = 1; i < LATENCY; i++) remSh[i] <= remSh[i-1];
    end
  end

  assign remDue = remSh[LATENCY-1];

  // R2
  r2_latency_chk: assert property (@(posedge clk) disable iff (rst)
    outValid == vldSh[LATENCY-1]);

  // R1
  r1_result_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> crcOut == refMod(remDue));

  // R6
  r6_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && remDue[CRC_W-1:0] == '0) |-> crcOut == remDue[REM_W-1:CRC_W]);

  // R5
  r5_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(crcOut));

endmodule

bind crc32_barrett_reduce crc32_barrett_reduce_chk #(
  .CRC_W   (CRC_W),
  .LATENCY (LATENCY),
  .P_CONST (P_CONST)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inRem    (inRem),
  .outValid (outValid),
  .crcOut   (crcOut)
);

// File: tb/crc32_barrett_reduce_tb.sv
`timescale 1ns/1ps
module crc32_barrett_reduce_tb;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [63:0] inRem = '0;
  logic        outValid;
  logic [31:0] crcOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  logic        hv [LAT];
  logic [31:0] he [LAT];
  string       ht [LAT];
  string       phaseTag = "R2";
  logic [31:0] lastCrc = '0;
  logic [63:0] lfsr = 64'h9E3779B97F4A7C15;

  always #2 clk = ~clk;

  crc32_barrett_reduce #(.LATENCY(LAT)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inRem(inRem),
    .outValid(outValid), .crcOut(crcOut)
  );

  // Normal-domain long division on reversed operand, result reversed back.
  function automatic logic [31:0] refCrc(input logic [63:0] r);
    logic [63:0] m;
    logic [31:0] o;
    for (int i = 0; i < 64; i++) m[i] = r[63-i];
    for (int i = 63; i >= 32; i--) begin
      if (m[i]) m = m ^ (64'h104C11DB7 << (i - 32));
    end
    for (int i = 0; i < 32; i++) o[i] = m[31-i];
    return o;
  endfunction

  function automatic logic [63:0] nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr;
  endfunction

  task automatic step(input logic v, input logic [63:0] d);
    @(negedge clk);
    checkCount++;
    if (outValid !== hv[LAT-1]) begin
      failCount++;
      $display("FAIL %s outValid actual %b expected %b", ht[LAT-1], outValid, hv[LAT-1]);
    end
    checkCount++;
    if (hv[LAT-1]) begin
      if (crcOut !== he[LAT-1]) begin
        failCount++;
        $display("FAIL %s crcOut actual %h expected %h", ht[LAT-1], crcOut, he[LAT-1]);
      end
      lastCrc = he[LAT-1];
    end else if (crcOut !== lastCrc) begin
      failCount++;
      $display("FAIL R5 R7 hold crcOut actual %h expected %h", crcOut, lastCrc);
    end
    for (int i = LAT - 1; i > 0; i--) begin
      hv[i] = hv[i-1]; he[i] = he[i-1]; ht[i] = ht[i-1];
    end
    hv[0] = v;
    he[0] = refCrc(d);
    ht[0] = (d[31:0] == 32'h0) ? {phaseTag, " R6"} : {phaseTag, " R1"};
    inValid = v;
    inRem   = d;
  endtask

  initial begin : watchdog
    #(4ns * 200000);
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL R2 watchdog expired actual running expected done");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < LAT; i++) begin hv[i] = 1'b0; he[i] = '0; ht[i] = "R2"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R4: reset state
    checkCount++;
    if (outValid !== 1'b0 || crcOut !== 32'h0) begin
      failCount++;
      $display("FAIL R4 reset actual %b/%h expected 0/00000000", outValid, crcOut);
    end
    rst = 1'b0;

    // R3: single-bit operands, back-to-back
    phaseTag = "R2 R3";
    for (int b = 0; b < 64; b++) step(1'b1, 64'h1 << b);

    // Every byte value in every byte lane, back-to-back
    for (int lane = 0; lane < 8; lane++)
      for (int v = 0; v < 256; v++) step(1'b1, 64'(v) << (8 * lane));

    // R7: random operands with junk on idle cycles
    phaseTag = "R2 R7";
    for (int n = 0; n < 1500; n++) begin
      if (n % 3 == 2) step(1'b0, nextRand());
      else            step(1'b1, nextRand());
    end

    // R6: low word zero
    phaseTag = "R2";
    for (int n = 0; n < 64; n++) step(1'b1, {nextRand() >> 32, 32'h0});
    step(1'b1, 64'hFFFFFFFF_00000000);
    step(1'b1, 64'hFFFFFFFF_FFFFFFFF);

    // Drain with junk and no strobe
    phaseTag = "R5 R7";
    for (int n = 0; n < LAT + 4; n++) step(1'b0, nextRand());

    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule